// File: doc/BRIEF.md
# Terminal Error Beep Sequencer

When a fatal fault stops the system, this block plays an 8-bit error code on the speaker. The byte is cut into 2-bit slices, and the most significant slice is played first. Each slice becomes a burst of short beeps, one more beep than the slice's value. Every code therefore sounds as four bursts, from 1-1-1-1 up to 4-4-4-4. For example, code 0x16 sounds as 1-2-2-3.

The block is loaded with a one-cycle start pulse that carries the code. While it plays, it drives a single speaker-enable line and holds busy high. After the last beep it gives a one-cycle done pulse. Three cycle-count parameters set the timing: the beep length, the silence between beeps of one burst, and a longer silence between bursts. Tone generation is not part of this block.

Top module: `beep_seq`

## Requirements
- R1: In the idle state, a start pulse captures `code_i`. `busy_o` is high from the next cycle, and the first beep begins in that same cycle.
- R2: Exactly four bursts are played. Burst k (k = 0..3) uses bits [7-2k : 6-2k] of the captured code.
- R3: Burst k has (slice value + 1) beeps, which gives 1 to 4 beeps per burst.
- R4: Each beep holds `spk_en_o` high for exactly ON_CYC consecutive cycles.
- R5: Two beeps of the same burst are separated by exactly GAP_CYC low cycles.
- R6: Two consecutive bursts are separated by exactly GRP_GAP_CYC low cycles, and GRP_GAP_CYC is greater than GAP_CYC.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the last high cycle of the final beep. In that cycle `busy_o` and `spk_en_o` are both low.
- R8: A start pulse that arrives while `busy_o` is high has no effect on the pattern being played.
- R9: While `rst_n` is low, `spk_en_o`, `busy_o` and `done_o` are low. After `rst_n` is released, the block is idle and accepts a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to play `code_i` |
| code_i | input | 8 | Error code to play |
| spk_en_o | output | 1 | Speaker enable, high during a beep |
| busy_o | output | 1 | High while a pattern is being played |
| done_o | output | 1 | One-cycle pulse at the end of the pattern |

## Verification
The bench plays all 256 codes. It splits the speaker line into bursts by measuring each low interval, so it catches a design that reverses the slice order, is off by one in the beep count, or mixes up the two silence lengths. It checks the length of every beep, and it checks that done falls exactly one cycle after the last beep with busy low. This catches an extra idle cycle or a done pulse held too long. A second start pulse sent in the middle of a pattern must leave the pattern unchanged; a design that reloads the code would change the bursts. A reset in the middle of a pattern must silence the speaker at once, and a fresh pattern must play correctly afterwards.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_GAP  = 2'd2,
    ST_GGAP = 2'd3
  } beep_st_e;
endpackage

// File: rtl/beep_timer.sv
module beep_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/beep_slicer.sv
module beep_slicer #(
  parameter int CODE_W = 8,
  parameter int GRP_W  = 2,
  localparam int NGRP  = CODE_W / GRP_W,
  localparam int GI_W  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [GI_W-1:0]   grp_i,
  input  logic [GRP_W-1:0]  beep_i,
  output logic              last_beep_o,
  output logic              last_grp_o
);
  logic [GRP_W-1:0] slice [NGRP];

  // slot 0 is the most significant slice, played first
  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    assign slice[g] = code_i[CODE_W-1-g*GRP_W -: GRP_W];
  end

  assign last_beep_o = (beep_i == slice[grp_i]);
  assign last_grp_o  = (grp_i == GI_W'(NGRP - 1));
endmodule

// File: rtl/beep_seq.sv
module beep_seq #(
  parameter int CODE_W      = 8,
  parameter int GRP_W       = 2,
  parameter int ON_CYC      = 2,
  parameter int GAP_CYC     = 2,
  parameter int GRP_GAP_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              spk_en_o,
  output logic              busy_o,
  output logic              done_o
);
  import beep_pkg::*;

  localparam int NGRP  = CODE_W / GRP_W;
  localparam int GI_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int MAXC  = (ON_CYC > GRP_GAP_CYC) ? ON_CYC : GRP_GAP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  beep_st_e          st_q, st_d;
  logic [CODE_W-1:0] code_q;
  logic              code_en;
  logic [GI_W-1:0]   grp_q, grp_d;
  logic [GRP_W-1:0]  bidx_q, bidx_d;
  logic              pos_en;
  logic              done_d;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic              last_beep, last_grp;

  beep_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .expired_o(tmr_exp)
  );

  beep_slicer #(.CODE_W(CODE_W), .GRP_W(GRP_W)) u_slc (
    .code_i(code_q), .grp_i(grp_q), .beep_i(bidx_q),
    .last_beep_o(last_beep), .last_grp_o(last_grp)
  );

  always_comb begin
    st_d     = st_q;
    grp_d    = grp_q;
    bidx_d   = bidx_q;
    pos_en   = 1'b0;
    code_en  = 1'b0;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(ON_CYC - 1);
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        code_en  = 1'b1;
        pos_en   = 1'b1;
        grp_d    = '0;
        bidx_d   = '0;
        tmr_load = 1'b1;
        st_d     = ST_ON;
      end
      ST_ON: if (tmr_exp) begin
        tmr_load = 1'b1;
        pos_en   = 1'b1;
        if (!last_beep) begin
          bidx_d  = bidx_q + 1'b1;
          tmr_val = CNT_W'(GAP_CYC - 1);
          st_d    = ST_GAP;
        end else if (!last_grp) begin
          bidx_d  = '0;
          grp_d   = grp_q + 1'b1;
          tmr_val = CNT_W'(GRP_GAP_CYC - 1);
          st_d    = ST_GGAP;
        end else begin
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_GAP, ST_GGAP: if (tmr_exp) begin
        tmr_load = 1'b1;
        st_d     = ST_ON;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      bidx_q <= '0;
    end else if (pos_en) begin
      grp_q  <= grp_d;
      bidx_q <= bidx_d;
    end
  end

  assign spk_en_o = (st_q == ST_ON);
  assign busy_o   = (st_q != ST_IDLE);

  initial begin
    p_gap_order_r6: assert (GRP_GAP_CYC > GAP_CYC && GAP_CYC >= 1 && ON_CYC >= 1);
  end

  // run-length counter for the beep-width checks
  logic [CNT_W:0] on_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        on_run <= '0;
    else if (spk_en_o) on_run <= on_run + 1'b1;
    else               on_run <= '0;
  end

  p_beep_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spk_en_o |-> (on_run < (CNT_W+1)'(ON_CYC)));
  p_beep_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spk_en_o) |-> (on_run == (CNT_W+1)'(ON_CYC)));
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && spk_en_o));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(code_q));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !spk_en_o && $past(spk_en_o)));
endmodule

// File: tb/sim_beep_seq.sv
module sim_beep_seq;
  localparam int ON = 2, GAP = 2, GGAP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] code = '0;
  logic spk, busy, done;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  beep_seq #(.CODE_W(8), .GRP_W(2), .ON_CYC(ON), .GAP_CYC(GAP), .GRP_GAP_CYC(GGAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
    .spk_en_o(spk), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Plays one code; optional stray start (with another code) at cycle glitch_at.
  task automatic play(input logic [7:0] c, input int glitch_at, input logic [7:0] gcode);
    int cnt[4];
    int g = -1, hi = 0, lo = 0, cyc = 0;
    bit prev = 1'b0, on_ok = 1'b1, gap_ok = 1'b1, busy_ok = 1'b1, fin = 1'b0;
    int bad_hi = 0, bad_lo = 0;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    @(negedge clk); start = 1'b1; code = c;
    @(negedge clk); start = 1'b0; code = ~c;
    chk(busy && spk, "R1 busy/beep after start", {busy, spk}, 3);
    while (!fin && cyc < 400) begin
      if (spk && !prev) begin
        if (g < 0) begin g = 0; cnt[0] = 1; end
        else if (lo == GAP) cnt[g]++;
        else if (lo == GGAP) begin g++; if (g < 4) cnt[g] = 1; end
        else begin gap_ok = 1'b0; bad_lo = lo; end
        hi = 0;
      end
      if (!spk && prev && hi != ON) begin on_ok = 1'b0; bad_hi = hi; end
      if (spk) hi++; else lo++;
      if (spk && !prev) lo = 0;
      if (!spk && prev) lo = 1;
      if (done) begin
        fin = 1'b1;
        chk(!busy && !spk && prev, "R7 done after last beep", {busy, spk, prev}, 1);
      end else if (!busy) busy_ok = 1'b0;
      prev = spk;
      cyc++;
      if (!fin) begin
        if (cyc == glitch_at) begin start = 1'b1; code = gcode; end
        else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(fin, "R7 done seen", fin, 1);
    chk(busy_ok, "R1 busy held until done", busy_ok, 1);
    chk(on_ok, "R4 beep width", bad_hi, ON);
    chk(gap_ok, "R5/R6 gap length", bad_lo, GAP);
    chk(g == 3, "R2 four bursts", g + 1, 4);
    for (int k = 0; k < 4; k++) begin
      int exp_n = ((c >> (6 - 2 * k)) & 3) + 1;
      chk(cnt[k] == exp_n, $sformatf("R3 burst %0d of code %0h (R8 if stray start)", k, c),
          cnt[k], exp_n);
    end
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!spk && !busy && !done, "R9 reset state", {spk, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!spk && !busy && !done, "R9 idle after release", {spk, busy, done}, 0);
    for (int c = 0; c < 256; c++) play(8'(c), -1, 8'h00);
    play(8'h16, 3, 8'hFF);   // R8: stray start ignored
    play(8'hE4, 20, 8'h00);  // R8: stray start in a gap
    // R9: reset in the middle of a pattern
    @(negedge clk); start = 1'b1; code = 8'hFF;
    @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!spk && !busy && !done, "R9 mid-pattern reset", {spk, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    play(8'h1B, -1, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule